// File: doc/BRIEF.md
# Windowed Readout Address Sequencer

This block produces the pixel address stream that drives the readout of an imaging array, 320 columns by 256 rows by default. Pixel (0,0) is the lower-left pixel. A frame strobe captures a window description: start, size, reading order and output-channel count. Each later line strobe then emits one window row, one pixel per clock. Each pixel comes with its row address, its column address and the index of the output channel that carries it.

The window is placed on a grid whose horizontal step grows with the channel count: 2, 4 or 8 columns for 1, 2 or 4 channels. The vertical step is always 2 rows. The channel of a pixel comes from its physical column. The channel therefore stays the same when the image is mirrored, windowed or repeated. In normal order, successive pixels rotate through the channels in ascending order.

Top module: `win_readout_seq`

## Requirements
- R1: After reset, `pix_valid`, `line_end` and `frame_end` are low, and line strobes are ignored until a frame strobe arrives.
- R2: `frame_go` captures every configuration input. Changes to those inputs afterwards have no effect until the next `frame_go`. A `frame_go` during a line ends that line in the next cycle (`pix_valid` low) and rearms the frame from its first line.
- R3: A `line_go` sampled while armed and idle makes `pix_valid` high from the next cycle. It stays high for exactly one window width of consecutive cycles, one pixel per cycle. `line_end` is high on the last pixel only, and `pix_valid` is low in the cycle after it.
- R4: The horizontal step G is 2, 4 or 8 for `out_mode` 00, 01 or 1x. The first window column is `win_x`*G and the width is `span_x`*G. When `span_x` = 0, all columns are read starting at column 0, and `win_x` is ignored.
- R5: The first window row is `win_y`*2 and the height is `span_y`*2. When `span_y` = 0, all rows are read starting at row 0, and `win_y` is ignored.
- R6: `order[0]` = 0 reads the columns of a line from low to high. `order[0]` = 1 reads them from high to low.
- R7: `order[1]` = 0 reads the window rows from the lowest upward. `order[1]` = 1 starts from the highest window row and moves downward.
- R8: `frame_end` is high together with `line_end` on the last pixel of the last line. After that, `line_go` has no effect until the next `frame_go`.
- R9: `chan` is the physical column modulo N, with N = 1, 2 or 4 for `out_mode` 00, 01 or 1x. The order bits do not change it.
- R10: `order[2]` = 1 reads each window row twice in succession before moving to the next row, so the frame has twice as many lines.
- R11: A `line_go` that arrives while a line is being emitted is ignored. The line continues unchanged, and no extra line starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_go | input | 1 | Frame strobe: captures the configuration and rearms the frame |
| line_go | input | 1 | Line strobe: starts the next window row |
| win_x | input | WXW | Horizontal window start, in units of G |
| win_y | input | WYW | Vertical window start, in units of 2 rows |
| span_x | input | WXW | Window width in units of G; 0 selects the full width |
| span_y | input | WYW | Window height in units of 2 rows; 0 selects the full height |
| order | input | 3 | Bit 0 reverses the columns, bit 1 inverts the rows, bit 2 repeats each line |
| out_mode | input | 2 | 00 one channel, 01 two channels, 1x four channels |
| pix_valid | output | 1 | Address outputs carry a pixel |
| row_addr | output | RW | Physical row of the pixel |
| col_addr | output | CW | Physical column of the pixel |
| chan | output | 2 | Output channel index of the pixel |
| line_end | output | 1 | Last pixel of the current line |
| frame_end | output | 1 | Last pixel of the frame |

## Verification
The bench builds the sequencer with a 64-column by 16-row array. At that size a full frame, including a full frame with line repeat, takes only a few thousand cycles. This lets every full-window case and many random windows be walked pixel by pixel. With 64 columns, the largest horizontal step of 8 leaves only eight grid positions. Random windows therefore often touch both the left and right array edges in every channel mode. The 16 rows bring the top and bottom edges within reach for the invert case in the same way.

// File: rtl/win_readout_seq.sv
module win_readout_seq #(
  parameter int COLS = 320,
  parameter int ROWS = 256,
  parameter int WXW  = 8,
  parameter int WYW  = 7,
  localparam int CW  = $clog2(COLS),
  localparam int RW  = $clog2(ROWS)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           frame_go,
  input  logic           line_go,
  input  logic [WXW-1:0] win_x,
  input  logic [WYW-1:0] win_y,
  input  logic [WXW-1:0] span_x,
  input  logic [WYW-1:0] span_y,
  input  logic [2:0]     order,
  input  logic [1:0]     out_mode,
  output logic           pix_valid,
  output logic [RW-1:0]  row_addr,
  output logic [CW-1:0]  col_addr,
  output logic [1:0]     chan,
  output logic           line_end,
  output logic           frame_end
);

  logic [1:0]  gsh_n;
  logic [15:0] cs_n, cw_n, rs_n, rh_n;

  logic [CW:0] c0, cn, cx;
  logic [RW:0] r0, rn, ry;
  logic        rev, inv, rpt, rep, armed, busy;
  logic [1:0]  mode_q;
  logic        last_px, last_row;

  always_comb begin
    gsh_n = (out_mode == 2'b00) ? 2'd1 : (out_mode == 2'b01) ? 2'd2 : 2'd3;
    cs_n  = (span_x == '0) ? 16'd0 : 16'(win_x) << gsh_n;
    cw_n  = (span_x == '0) ? 16'(COLS) : 16'(span_x) << gsh_n;
    rs_n  = (span_y == '0) ? 16'd0 : 16'(win_y) << 1;
    rh_n  = (span_y == '0) ? 16'(ROWS) : 16'(span_y) << 1;
  end

  assign last_px  = busy && (cx == cn - 1'b1);
  assign last_row = (ry == rn - 1'b1) && (!rpt || rep);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c0 <= '0; cn <= '0; cx <= '0;
      r0 <= '0; rn <= '0; ry <= '0;
      rev <= 1'b0; inv <= 1'b0; rpt <= 1'b0; rep <= 1'b0;
      mode_q <= 2'b00; armed <= 1'b0; busy <= 1'b0;
    end else if (frame_go) begin
      c0 <= (CW+1)'(cs_n);
      cn <= (CW+1)'(cw_n);
      r0 <= (RW+1)'(rs_n);
      rn <= (RW+1)'(rh_n);
      rev <= order[0]; inv <= order[1]; rpt <= order[2];
      mode_q <= out_mode;
      armed <= 1'b1; busy <= 1'b0;
      cx <= '0; ry <= '0; rep <= 1'b0;
    end else if (busy) begin
      if (cx == cn - 1'b1) begin
        busy <= 1'b0;
        cx   <= '0;
        if (rpt && !rep) begin
          rep <= 1'b1;
        end else begin
          rep <= 1'b0;
          if (ry == rn - 1'b1) armed <= 1'b0;
          else                 ry    <= ry + 1'b1;
        end
      end else begin
        cx <= cx + 1'b1;
      end
    end else if (line_go && armed) begin
      busy <= 1'b1;
    end
  end

  assign pix_valid = busy;
  assign col_addr  = CW'(rev ? c0 + cn - 1'b1 - cx : c0 + cx);
  assign row_addr  = RW'(inv ? r0 + rn - 1'b1 - ry : r0 + ry);
  assign chan      = (mode_q == 2'b00) ? 2'b00 :
                     (mode_q == 2'b01) ? {1'b0, col_addr[0]} : col_addr[1:0];
  assign line_end  = last_px;
  assign frame_end = last_px && last_row;

endmodule

// File: rtl/win_readout_seq_chk.sv
module win_readout_seq_chk #(
  parameter int COLS = 320,
  parameter int CW   = 9,
  parameter int RW   = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          frame_go,
  input logic          pix_valid,
  input logic [RW-1:0] row_addr,
  input logic [CW-1:0] col_addr,
  input logic          line_end,
  input logic          frame_end
);

  p_eol_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    line_end |-> pix_valid);

  p_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    line_end |=> !pix_valid);

  p_eof_eol_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> line_end);

  p_col_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !line_end && !frame_go) |=>
      (pix_valid && ((col_addr == $past(col_addr) + 1'b1) ||
                     (col_addr == $past(col_addr) - 1'b1))));

  p_row_steady_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !line_end && !frame_go) |=> $stable(row_addr));

  p_col_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> (32'(col_addr) < COLS));

  p_abort_r2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_go |=> !pix_valid);

endmodule

bind win_readout_seq win_readout_seq_chk #(.COLS(COLS), .CW(CW), .RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_go(frame_go), .pix_valid(pix_valid),
  .row_addr(row_addr), .col_addr(col_addr), .line_end(line_end),
  .frame_end(frame_end)
);

// File: tb/win_readout_seq_bench.sv
module win_readout_seq_bench;
  localparam int CLK_PER = 10;
  localparam int NC = 64;
  localparam int NR = 16;
  localparam int CW = $clog2(NC);
  localparam int RW = $clog2(NR);

  logic clk = 1'b0, rst_n = 1'b0, frame_go = 1'b0, line_go = 1'b0;
  logic [7:0] win_x = '0, span_x = '0;
  logic [6:0] win_y = '0, span_y = '0;
  logic [2:0] order = '0;
  logic [1:0] out_mode = '0;
  logic pix_valid, line_end, frame_end;
  logic [RW-1:0] row_addr;
  logic [CW-1:0] col_addr;
  logic [1:0] chan;

  int n_chk = 0, n_bad = 0;
  int f_wx, f_wy, f_sx, f_sy, f_ord, f_md;

  always #(CLK_PER/2) clk = ~clk;

  win_readout_seq #(.COLS(NC), .ROWS(NR)) u_win_readout_seq (
    .clk(clk), .rst_n(rst_n), .frame_go(frame_go), .line_go(line_go),
    .win_x(win_x), .win_y(win_y), .span_x(span_x), .span_y(span_y),
    .order(order), .out_mode(out_mode), .pix_valid(pix_valid),
    .row_addr(row_addr), .col_addr(col_addr), .chan(chan),
    .line_end(line_end), .frame_end(frame_end));

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  function automatic int step_of(int md);
    return (md == 0) ? 2 : (md == 1) ? 4 : 8;
  endfunction

  function automatic int nch_of(int md);
    return (md == 0) ? 1 : (md == 1) ? 2 : 4;
  endfunction

  function automatic int lines_of();
    int rh = (f_sy == 0) ? NR : f_sy * 2;
    return f_ord[2] ? 2 * rh : rh;
  endfunction

  task automatic start_frame(int wx, int wy, int sx, int sy, int ord, int md);
    @(negedge clk);
    win_x = 8'(wx); win_y = 7'(wy); span_x = 8'(sx); span_y = 7'(sy);
    order = 3'(ord); out_mode = 2'(md); frame_go = 1'b1;
    f_wx = wx; f_wy = wy; f_sx = sx; f_sy = sy; f_ord = ord; f_md = md;
    @(negedge clk);
    frame_go = 1'b0;
    // R2: scramble the configuration inputs after capture
    win_x = 8'($urandom); win_y = 7'($urandom); span_x = 8'($urandom);
    span_y = 7'($urandom); order = 3'($urandom); out_mode = 2'($urandom);
  endtask

  task automatic read_line(int li, bit mid_pulse);
    int g = step_of(f_md);
    int n = nch_of(f_md);
    int c0 = (f_sx == 0) ? 0 : f_wx * g;
    int cw = (f_sx == 0) ? NC : f_sx * g;
    int r0 = (f_sy == 0) ? 0 : f_wy * 2;
    int rh = (f_sy == 0) ? NR : f_sy * 2;
    int ri = f_ord[2] ? li / 2 : li;
    int er = f_ord[1] ? r0 + rh - 1 - ri : r0 + ri;
    int nl = lines_of();
    line_go = 1'b1;
    @(negedge clk);
    line_go = 1'b0;
    for (int k = 0; k < cw; k++) begin
      int ec;
      if (k > 0) @(negedge clk);
      ec = f_ord[0] ? c0 + cw - 1 - k : c0 + k;
      chk("R3", "valid", int'(pix_valid), 1);
      chk("R6", "col", int'(col_addr), ec);
      chk("R7", "row", int'(row_addr), er);
      chk("R9", "chan", int'(chan), ec % n);
      chk("R3", "line_end", int'(line_end), (k == cw - 1) ? 1 : 0);
      chk("R8", "frame_end", int'(frame_end), (k == cw - 1 && li == nl - 1) ? 1 : 0);
      line_go = (mid_pulse && k == 0) ? 1'b1 : 1'b0; // R11
    end
    @(negedge clk);
    line_go = 1'b0;
    chk("R3", "valid after line", int'(pix_valid), 0);
  endtask

  task automatic run_frame(bit allow_pulse);
    int nl = lines_of();
    for (int li = 0; li < nl; li++) begin
      read_line(li, allow_pulse && ($urandom_range(0, 3) == 0));
      repeat ($urandom_range(0, 3)) @(negedge clk);
    end
    // R8: line strobe after the frame is finished has no effect
    line_go = 1'b1;
    @(negedge clk);
    line_go = 1'b0;
    for (int k = 0; k < 3; k++) begin
      chk("R8", "valid after frame", int'(pix_valid), 0);
      @(negedge clk);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL R3 watchdog act=timeout exp=finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk("R1", "valid in reset", int'(pix_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "line_end", int'(line_end), 0);
    chk("R1", "frame_end", int'(frame_end), 0);
    line_go = 1'b1;
    @(negedge clk);
    line_go = 1'b0;
    chk("R1", "unarmed line strobe", int'(pix_valid), 0);

    // full frame, default order (R4, R5)
    start_frame(0, 0, 0, 0, 0, 0);
    run_frame(1'b0);
    // full frame with ignored start fields, mirrored and repeated (R4, R5, R10)
    start_frame(5, 3, 0, 0, 7, 2);
    run_frame(1'b0);
    // out_mode 11 behaves as four channels (R9)
    start_frame(1, 1, 4, 3, 1, 3);
    run_frame(1'b1);
    // edge windows: right and top edges under invert (R4, R7)
    start_frame(4, 4, 4, 4, 2, 2);
    run_frame(1'b1);

    // abort in the middle of a line (R2)
    start_frame(0, 0, 0, 0, 0, 1);
    line_go = 1'b1;
    @(negedge clk);
    line_go = 1'b0;
    @(negedge clk);
    @(negedge clk);
    start_frame(2, 1, 3, 2, 1, 1);
    chk("R2", "valid after abort", int'(pix_valid), 0);
    run_frame(1'b1);

    for (int fr = 0; fr < 40; fr++) begin
      int md = $urandom_range(0, 3);
      int mu = NC / step_of(md);
      int mv = NR / 2;
      int sx = ($urandom_range(0, 5) == 0) ? 0 : $urandom_range(1, mu);
      int wx = (sx == 0) ? $urandom_range(0, 255) : $urandom_range(0, mu - sx);
      int sy = ($urandom_range(0, 5) == 0) ? 0 : $urandom_range(1, mv);
      int wy = (sy == 0) ? $urandom_range(0, 127) : $urandom_range(0, mv - sy);
      start_frame(wx, wy, sx, sy, $urandom_range(0, 7), md);
      run_frame(1'b1);
    end

    summary();
    $finish;
  end
endmodule